// File: doc/BRIEF.md
# Ring-of-Rings Directory Router

This cell sits where a local ring of processor caches meets a higher ring of sibling cells. Both rings are unidirectional. A packet accepted on a ring input leaves on exactly one output, or is consumed. It may continue along the ring it arrived on, climb from the local ring to the higher ring, or descend from the higher ring to the local ring. The choice depends on the packet kind, on the requester's ring number carried in the packet, and on a directory that records, for every 128-byte line owned by the local ring, whether that line is invalid, shared or exclusive there.

The directory is kept one row per page, and each row holds a 2-bit state for each of the 128 lines in the page. Grants passing through the cell update the directory. A shared grant marks the line shared. An exclusive grant leaving the local ring clears the line. An exclusive grant arriving from the higher ring makes the cell send its own invalidate packet once around the local ring, and the line becomes exclusive only when that invalidate comes back. Both outputs are registered and use valid/ready handshakes. Each output takes at most one packet per cycle and gives fixed priority to traffic already on its ring.

Top module: `ring_dir_router`

## Requirements
- R1: A packet is {kind[2:0], page[PageW-1:0], line[6:0], ring[RingW-1:0], proc[ProcW-1:0]}, MSB first. The kinds are 0 shared request, 1 exclusive request, 2 shared grant, 3 exclusive grant and 4 invalidate. Line states are 00 invalid, 01 shared and 10 exclusive. After reset every line is invalid and both outputs are idle.
- R2: A request from the local ring goes to the upper output when its line is invalid. Otherwise it passes unchanged to the local output.
- R3: A request from the upper ring descends to the local output when its line is shared or exclusive. Otherwise it passes unchanged to the upper output.
- R4: A grant from the local ring whose ring field differs from MyRing climbs to the upper output. If the ring field equals MyRing, it stays on the local output. A grant from the upper ring descends when its ring field equals MyRing and passes on the upper ring otherwise.
- R5: A shared grant handled by the cell on either port sets its line to shared.
- R6: An exclusive grant from the local ring sets its line to invalid when it climbs, and to exclusive when it stays local.
- R7: After an exclusive grant descends from the upper ring, the cell emits on the local output, in the next free cycle, an invalidate with the same page and line, ring = MyRing and proc all ones. The line stays in its earlier state until that invalidate returns at the local input, and then becomes exclusive. While an invalidate is outstanding, a further descending exclusive grant is held off (upper input ready low).
- R8: An invalidate that the cell did not originate passes unchanged along the ring it arrived on. The cell's own invalidate is always accepted and is not forwarded.
- R9: Each output loads at most one packet per cycle. On the local output the priority is the cell's invalidate, then local-ring traffic, then descending traffic. On the upper output, upper-ring traffic comes before climbing traffic.
- R10: A valid output whose ready is low holds its packet unchanged, and the input whose packet targets that output sees ready low until the output drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowInValid | input | 1 | Local ring input valid |
| lowInReady | output | 1 | Local ring input accepted |
| lowInPkt | input | PktW | Local ring input packet |
| upInValid | input | 1 | Upper ring input valid |
| upInReady | output | 1 | Upper ring input accepted |
| upInPkt | input | PktW | Upper ring input packet |
| lowOutValid | output | 1 | Local ring output valid |
| lowOutReady | input | 1 | Next local stop can take a packet |
| lowOutPkt | output | PktW | Local ring output packet |
| upOutValid | output | 1 | Upper ring output valid |
| upOutReady | input | 1 | Next upper stop can take a packet |
| upOutPkt | output | PktW | Upper ring output packet |

## Verification
The bench targets the exclusive-grant handshake from the upper ring. A design that marks the line exclusive as soon as the grant descends would send a later upper request for that line down instead of up. A design that forgets the one-outstanding limit would accept a second exclusive grant while the first invalidate is still on the ring. The bench also drives simultaneous traffic on both inputs toward one output, where wrong priority shows up as the wrong packet leaving. It stalls an output to catch a register that overwrites or drops its contents. Directory corruption shows up as wrong routing of later requests after each grant kind.

// File: rtl/ring_dir_pkg.sv
package ring_dir_pkg;
  localparam int KindW = 3;
  localparam int LineW = 7;
  localparam int LinesPerPage = 1 << LineW;

  localparam logic [KindW-1:0] kReqSh = 3'd0;
  localparam logic [KindW-1:0] kReqEx = 3'd1;
  localparam logic [KindW-1:0] kRspSh = 3'd2;
  localparam logic [KindW-1:0] kRspEx = 3'd3;
  localparam logic [KindW-1:0] kInv   = 3'd4;

  localparam logic [1:0] stInvalid = 2'b00;
  localparam logic [1:0] stShared  = 2'b01;
  localparam logic [1:0] stExcl    = 2'b10;

  typedef enum logic [1:0] {LO_NONE, LO_LIN, LO_UIN, LO_INV} loSel_e;
  typedef enum logic [1:0] {UP_NONE, UP_LIN, UP_UIN} upSel_e;

  typedef struct packed {
    loSel_e     loSel;
    upSel_e     upSel;
    logic       linWr;
    logic [1:0] linWrState;
    logic       uinWr;
    logic       invLoad;
  } ctrl_t;
endpackage

// File: rtl/ring_dir_datapath.sv
module ring_dir_datapath
  import ring_dir_pkg::*;
#(
  parameter int PageW  = 2,
  parameter int RingW  = 3,
  parameter int ProcW  = 5,
  parameter int MyRing = 2
) (
  input  logic clk,
  input  logic rstN,
  input  ctrl_t ctrl,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowInPkt,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] upInPkt,
  input  logic lowOutReady,
  input  logic upOutReady,
  output logic lowOutValid,
  output logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowOutPkt,
  output logic upOutValid,
  output logic [KindW+PageW+LineW+RingW+ProcW-1:0] upOutPkt,
  output logic [1:0] linState,
  output logic [1:0] uinState,
  output logic loFree,
  output logic upFree
);
  localparam int PktW     = KindW + PageW + LineW + RingW + ProcW;
  localparam int NumPages = 1 << PageW;
  localparam int LineLsb  = ProcW + RingW;
  localparam int PageLsb  = LineLsb + LineW;

  logic [2*LinesPerPage-1:0] dirMem [NumPages];

  logic [PageW-1:0] linPage, uinPage, invPage;
  logic [LineW-1:0] linLine, uinLine, invLine;

  assign linPage = lowInPkt[PageLsb +: PageW];
  assign linLine = lowInPkt[LineLsb +: LineW];
  assign uinPage = upInPkt[PageLsb +: PageW];
  assign uinLine = upInPkt[LineLsb +: LineW];

  assign linState = dirMem[linPage][{linLine, 1'b0} +: 2];
  assign uinState = dirMem[uinPage][{uinLine, 1'b0} +: 2];

  assign loFree = !lowOutValid || lowOutReady;
  assign upFree = !upOutValid || upOutReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NumPages; p++) dirMem[p] <= '0;
    end else begin
      if (ctrl.linWr) dirMem[linPage][{linLine, 1'b0} +: 2] <= ctrl.linWrState;
      if (ctrl.uinWr) dirMem[uinPage][{uinLine, 1'b0} +: 2] <= stShared;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invPage <= '0;
      invLine <= '0;
    end else if (ctrl.invLoad) begin
      invPage <= uinPage;
      invLine <= uinLine;
    end
  end

  logic [PktW-1:0] invPkt;
  assign invPkt = {kInv, invPage, invLine, RingW'(MyRing), {ProcW{1'b1}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowOutValid <= 1'b0;
      lowOutPkt   <= '0;
    end else begin
      unique case (ctrl.loSel)
        LO_LIN:  begin lowOutValid <= 1'b1; lowOutPkt <= lowInPkt; end
        LO_UIN:  begin lowOutValid <= 1'b1; lowOutPkt <= upInPkt;  end
        LO_INV:  begin lowOutValid <= 1'b1; lowOutPkt <= invPkt;   end
        default: if (lowOutReady) lowOutValid <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upOutValid <= 1'b0;
      upOutPkt   <= '0;
    end else begin
      unique case (ctrl.upSel)
        UP_LIN:  begin upOutValid <= 1'b1; upOutPkt <= lowInPkt; end
        UP_UIN:  begin upOutValid <= 1'b1; upOutPkt <= upInPkt;  end
        default: if (upOutReady) upOutValid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ring_dir_control.sv
module ring_dir_control
  import ring_dir_pkg::*;
#(
  parameter int PageW  = 2,
  parameter int RingW  = 3,
  parameter int ProcW  = 5,
  parameter int MyRing = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowInValid,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowInPkt,
  input  logic upInValid,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] upInPkt,
  input  logic [1:0] linState,
  input  logic [1:0] uinState,
  input  logic loFree,
  input  logic upFree,
  output logic lowInReady,
  output logic upInReady,
  output ctrl_t ctrl
);
  localparam int PktW = KindW + PageW + LineW + RingW + ProcW;

  typedef enum logic [1:0] {D_NONE, D_LOW, D_UP} dest_e;
  typedef enum logic [1:0] {I_IDLE, I_SEND, I_WAIT} inv_e;

  inv_e invState;

  logic [KindW-1:0] linKind, uinKind;
  logic [RingW-1:0] linRing, uinRing;
  logic [ProcW-1:0] linProc;
  logic linLocal, uinLocal, linOwnInv, uinStarts;
  dest_e linDest, uinDest;
  logic linGo, uinGo, invSend;

  assign linKind  = lowInPkt[PktW-1 -: KindW];
  assign uinKind  = upInPkt[PktW-1 -: KindW];
  assign linRing  = lowInPkt[ProcW +: RingW];
  assign uinRing  = upInPkt[ProcW +: RingW];
  assign linProc  = lowInPkt[ProcW-1:0];
  assign linLocal = linRing == RingW'(MyRing);
  assign uinLocal = uinRing == RingW'(MyRing);
  assign linOwnInv = linKind == kInv && linLocal && linProc == {ProcW{1'b1}};
  assign uinStarts = uinKind == kRspEx && uinLocal;

  always_comb begin
    unique case (linKind)
      kReqSh, kReqEx: linDest = (linState == stInvalid) ? D_UP : D_LOW;
      kRspSh, kRspEx: linDest = linLocal ? D_LOW : D_UP;
      kInv:           linDest = linOwnInv ? D_NONE : D_LOW;
      default:        linDest = D_LOW;
    endcase
    unique case (uinKind)
      kReqSh, kReqEx: uinDest = (uinState != stInvalid) ? D_LOW : D_UP;
      kRspSh, kRspEx: uinDest = uinLocal ? D_LOW : D_UP;
      default:        uinDest = D_UP;
    endcase
  end

  assign invSend = invState == I_SEND && loFree;

  assign linGo = lowInValid && (linDest == D_NONE
      || (linDest == D_LOW && loFree && invState != I_SEND)
      || (linDest == D_UP && upFree && !(upInValid && uinDest == D_UP)));

  assign uinGo = upInValid && ((uinDest == D_UP && upFree)
      || (uinDest == D_LOW && loFree && invState != I_SEND
          && !(lowInValid && linDest == D_LOW)
          && (!uinStarts || invState == I_IDLE)));

  assign lowInReady = linGo;
  assign upInReady  = uinGo;

  always_comb begin
    ctrl = '0;
    if (invSend)                         ctrl.loSel = LO_INV;
    else if (linGo && linDest == D_LOW)  ctrl.loSel = LO_LIN;
    else if (uinGo && uinDest == D_LOW)  ctrl.loSel = LO_UIN;
    if (uinGo && uinDest == D_UP)        ctrl.upSel = UP_UIN;
    else if (linGo && linDest == D_UP)   ctrl.upSel = UP_LIN;

    if (linGo) begin
      if (linKind == kRspSh) begin
        ctrl.linWr = 1'b1; ctrl.linWrState = stShared;
      end else if (linKind == kRspEx) begin
        ctrl.linWr = 1'b1; ctrl.linWrState = linLocal ? stExcl : stInvalid;
      end else if (linOwnInv && invState == I_WAIT) begin
        ctrl.linWr = 1'b1; ctrl.linWrState = stExcl;
      end
    end
    ctrl.uinWr   = uinGo && uinDest == D_LOW && uinKind == kRspSh;
    ctrl.invLoad = uinGo && uinStarts;
  end

  always_ff @(posedge clk) begin
    if (!rstN) invState <= I_IDLE;
    else begin
      unique case (invState)
        I_IDLE:  if (ctrl.invLoad) invState <= I_SEND;
        I_SEND:  if (invSend) invState <= I_WAIT;
        I_WAIT:  if (linGo && linOwnInv) invState <= I_IDLE;
        default: invState <= I_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_dir_router.sv
module ring_dir_router
  import ring_dir_pkg::*;
#(
  parameter int PageW  = 2,
  parameter int RingW  = 3,
  parameter int ProcW  = 5,
  parameter int MyRing = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowInValid,
  output logic lowInReady,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowInPkt,
  input  logic upInValid,
  output logic upInReady,
  input  logic [KindW+PageW+LineW+RingW+ProcW-1:0] upInPkt,
  output logic lowOutValid,
  input  logic lowOutReady,
  output logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowOutPkt,
  output logic upOutValid,
  input  logic upOutReady,
  output logic [KindW+PageW+LineW+RingW+ProcW-1:0] upOutPkt
);
  ctrl_t ctrl;
  logic [1:0] linState, uinState;
  logic loFree, upFree;

  ring_dir_control #(.PageW(PageW), .RingW(RingW), .ProcW(ProcW), .MyRing(MyRing)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lowInValid(lowInValid), .lowInPkt(lowInPkt),
    .upInValid(upInValid), .upInPkt(upInPkt),
    .linState(linState), .uinState(uinState),
    .loFree(loFree), .upFree(upFree),
    .lowInReady(lowInReady), .upInReady(upInReady),
    .ctrl(ctrl)
  );

  ring_dir_datapath #(.PageW(PageW), .RingW(RingW), .ProcW(ProcW), .MyRing(MyRing)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .lowInPkt(lowInPkt), .upInPkt(upInPkt),
    .lowOutReady(lowOutReady), .upOutReady(upOutReady),
    .lowOutValid(lowOutValid), .lowOutPkt(lowOutPkt),
    .upOutValid(upOutValid), .upOutPkt(upOutPkt),
    .linState(linState), .uinState(uinState),
    .loFree(loFree), .upFree(upFree)
  );
endmodule

// File: rtl/ring_dir_router_chk.sv
module ring_dir_router_chk
  import ring_dir_pkg::*;
#(
  parameter int PageW  = 2,
  parameter int RingW  = 3,
  parameter int ProcW  = 5,
  parameter int MyRing = 2
) (
  input logic clk,
  input logic rstN,
  input logic lowInValid,
  input logic lowInReady,
  input logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowInPkt,
  input logic upInValid,
  input logic upInReady,
  input logic [KindW+PageW+LineW+RingW+ProcW-1:0] upInPkt,
  input logic lowOutValid,
  input logic lowOutReady,
  input logic [KindW+PageW+LineW+RingW+ProcW-1:0] lowOutPkt,
  input logic upOutValid,
  input logic upOutReady,
  input logic [KindW+PageW+LineW+RingW+ProcW-1:0] upOutPkt
);
  localparam int PktW = KindW + PageW + LineW + RingW + ProcW;

  logic [KindW-1:0] linKind, uinKind;
  logic linLocal, uinLocal, linOwnInv;
  assign linKind   = lowInPkt[PktW-1 -: KindW];
  assign uinKind   = upInPkt[PktW-1 -: KindW];
  assign linLocal  = lowInPkt[ProcW +: RingW] == RingW'(MyRing);
  assign uinLocal  = upInPkt[ProcW +: RingW] == RingW'(MyRing);
  assign linOwnInv = linKind == kInv && linLocal && lowInPkt[ProcW-1:0] == {ProcW{1'b1}};

  // R10: a stalled local output keeps its packet
  a_r10_low_hold: assert property (@(posedge clk) disable iff (!rstN)
    lowOutValid && !lowOutReady |=> lowOutValid && $stable(lowOutPkt));

  // R10: a stalled upper output keeps its packet
  a_r10_up_hold: assert property (@(posedge clk) disable iff (!rstN)
    upOutValid && !upOutReady |=> upOutValid && $stable(upOutPkt));

  // R8: the cell's own invalidate is never refused
  a_r8_own_inv_taken: assert property (@(posedge clk) disable iff (!rstN)
    lowInValid && linOwnInv |-> lowInReady);

  // R7: an accepted exclusive grant for this ring appears on the local output
  a_r7_grant_descends: assert property (@(posedge clk) disable iff (!rstN)
    upInValid && upInReady && uinKind == kRspEx && uinLocal
    |=> lowOutValid && lowOutPkt == $past(upInPkt));

  // R4: an accepted grant for another ring climbs
  a_r4_grant_climbs: assert property (@(posedge clk) disable iff (!rstN)
    lowInValid && lowInReady && (linKind == kRspSh || linKind == kRspEx) && !linLocal
    |=> upOutValid && upOutPkt == $past(lowInPkt));
endmodule

bind ring_dir_router ring_dir_router_chk #(
  .PageW(PageW), .RingW(RingW), .ProcW(ProcW), .MyRing(MyRing)
) u_chk (
  .clk(clk), .rstN(rstN),
  .lowInValid(lowInValid), .lowInReady(lowInReady), .lowInPkt(lowInPkt),
  .upInValid(upInValid), .upInReady(upInReady), .upInPkt(upInPkt),
  .lowOutValid(lowOutValid), .lowOutReady(lowOutReady), .lowOutPkt(lowOutPkt),
  .upOutValid(upOutValid), .upOutReady(upOutReady), .upOutPkt(upOutPkt)
);

// File: tb/test_ring_dir_router.sv
module test_ring_dir_router;
  localparam int PageW = 2, RingW = 3, ProcW = 5, MyRing = 2;
  localparam int PktW = 3 + PageW + 7 + RingW + ProcW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowInValid = 1'b0, upInValid = 1'b0;
  logic lowOutReady = 1'b1, upOutReady = 1'b1;
  logic [PktW-1:0] lowInPkt = '0, upInPkt = '0;
  logic lowInReady, upInReady, lowOutValid, upOutValid;
  logic [PktW-1:0] lowOutPkt, upOutPkt;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ring_dir_router #(.PageW(PageW), .RingW(RingW), .ProcW(ProcW), .MyRing(MyRing)) i_ring_dir_router (
    .clk(clk), .rstN(rstN),
    .lowInValid(lowInValid), .lowInReady(lowInReady), .lowInPkt(lowInPkt),
    .upInValid(upInValid), .upInReady(upInReady), .upInPkt(upInPkt),
    .lowOutValid(lowOutValid), .lowOutReady(lowOutReady), .lowOutPkt(lowOutPkt),
    .upOutValid(upOutValid), .upOutReady(upOutReady), .upOutPkt(upOutPkt)
  );

  function automatic logic [PktW-1:0] mk(input logic [2:0] k, input logic [PageW-1:0] pg,
      input logic [6:0] ln, input logic [RingW-1:0] rg, input logic [ProcW-1:0] pr);
    return {k, pg, ln, rg, pr};
  endfunction

  localparam logic [RingW-1:0] Mine = RingW'(MyRing);
  localparam logic [RingW-1:0] Far  = 3'd5;
  localparam logic [ProcW-1:0] Own  = '1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic lv, input logic [PktW-1:0] lp, input logic uv,
      input logic [PktW-1:0] up, output logic la, output logic ua);
    lowInValid = lv; lowInPkt = lp; upInValid = uv; upInPkt = up;
    #1;
    la = lowInReady & lv;
    ua = upInReady & uv;
    @(negedge clk);
    lowInValid = 1'b0; upInValid = 1'b0;
  endtask

  // one packet on one port, then check where it went
  task automatic one(input string req, input bit fromLow, input logic [PktW-1:0] p,
      input bit expLo, input bit expUp);
    logic la, ua;
    if (fromLow) cyc(1'b1, p, 1'b0, '0, la, ua);
    else         cyc(1'b0, '0, 1'b1, p, la, ua);
    chk({req, " accepted"}, 32'(fromLow ? la : ua), 32'd1);
    chk({req, " low out valid"}, 32'(lowOutValid), 32'(expLo));
    chk({req, " up out valid"}, 32'(upOutValid), 32'(expUp));
    if (expLo) chk({req, " low out pkt"}, 32'(lowOutPkt), 32'(p));
    if (expUp) chk({req, " up out pkt"}, 32'(upOutPkt), 32'(p));
  endtask

  task automatic t_reset();
    chk("R1 reset low out idle", 32'(lowOutValid), 32'd0);
    chk("R1 reset up out idle", 32'(upOutValid), 32'd0);
  endtask

  task automatic t_basic();
    one("R2 miss climbs", 1, mk(3'd0, 2'd1, 7'd5, Mine, 5'd4), 0, 1);
    one("R4 far shared grant climbs", 1, mk(3'd2, 2'd1, 7'd5, Far, 5'd3), 0, 1);
    one("R5 R2 shared line request stays low", 1, mk(3'd1, 2'd1, 7'd5, Mine, 5'd6), 1, 0);
    one("R3 held line descends", 0, mk(3'd0, 2'd1, 7'd5, Far, 5'd1), 1, 0);
    one("R3 absent line passes up", 0, mk(3'd0, 2'd2, 7'd100, Far, 5'd1), 0, 1);
  endtask

  task automatic t_local_grants();
    one("R4 local shared grant stays low", 1, mk(3'd2, 2'd0, 7'd64, Mine, 5'd2), 1, 0);
    one("R5 line shared after local grant", 0, mk(3'd0, 2'd0, 7'd64, Far, 5'd1), 1, 0);
    one("R4 upper shared grant descends", 0, mk(3'd2, 2'd1, 7'd0, Mine, 5'd7), 1, 0);
    one("R5 line shared after descent", 1, mk(3'd0, 2'd1, 7'd0, Mine, 5'd8), 1, 0);
    one("R4 upper far grant passes", 0, mk(3'd2, 2'd0, 7'd9, Far, 5'd7), 0, 1);
  endtask

  task automatic t_exclusive_low();
    one("R6 far exclusive grant climbs", 1, mk(3'd3, 2'd1, 7'd5, Far, 5'd3), 0, 1);
    one("R6 line invalid after climb", 0, mk(3'd0, 2'd1, 7'd5, Far, 5'd1), 0, 1);
    one("R6 local exclusive grant stays", 1, mk(3'd3, 2'd0, 7'd0, Mine, 5'd2), 1, 0);
    one("R6 line exclusive after local", 0, mk(3'd1, 2'd0, 7'd0, Far, 5'd1), 1, 0);
  endtask

  task automatic t_exclusive_up();
    logic la, ua;
    logic [PktW-1:0] g = mk(3'd3, 2'd3, 7'd127, Mine, 5'd9);
    logic [PktW-1:0] g2 = mk(3'd3, 2'd3, 7'd1, Mine, 5'd9);
    one("R7 exclusive grant descends", 0, g, 1, 0);
    cyc(1'b0, '0, 1'b0, '0, la, ua);
    chk("R7 invalidate emitted valid", 32'(lowOutValid), 32'd1);
    chk("R7 invalidate packet", 32'(lowOutPkt), 32'(mk(3'd4, 2'd3, 7'd127, Mine, Own)));
    one("R7 line not exclusive before return", 0, mk(3'd0, 2'd3, 7'd127, Far, 5'd1), 0, 1);
    cyc(1'b0, '0, 1'b1, g2, la, ua);
    chk("R7 second exclusive grant held off", 32'(ua), 32'd0);
    chk("R7 held grant not forwarded", 32'(lowOutValid), 32'd0);
    one("R8 own invalidate consumed", 1, mk(3'd4, 2'd3, 7'd127, Mine, Own), 0, 0);
    one("R7 line exclusive after return", 0, mk(3'd0, 2'd3, 7'd127, Far, 5'd1), 1, 0);
    one("R7 second grant now taken", 0, g2, 1, 0);
    cyc(1'b0, '0, 1'b0, '0, la, ua);
    chk("R7 second invalidate", 32'(lowOutPkt), 32'(mk(3'd4, 2'd3, 7'd1, Mine, Own)));
    one("R8 second own invalidate consumed", 1, mk(3'd4, 2'd3, 7'd1, Mine, Own), 0, 0);
  endtask

  task automatic t_foreign_inv();
    one("R8 foreign invalidate passes low", 1, mk(3'd4, 2'd0, 7'd0, Mine, 5'd3), 1, 0);
    one("R8 upper invalidate passes up", 0, mk(3'd4, 2'd0, 7'd0, Mine, Own), 0, 1);
  endtask

  task automatic t_priority();
    logic la, ua;
    logic [PktW-1:0] a = mk(3'd0, 2'd0, 7'd0, Mine, 5'd1);
    logic [PktW-1:0] b = mk(3'd0, 2'd0, 7'd0, Far, 5'd2);
    logic [PktW-1:0] c = mk(3'd0, 2'd2, 7'd100, Mine, 5'd1);
    logic [PktW-1:0] d = mk(3'd0, 2'd2, 7'd100, Far, 5'd2);
    cyc(1'b1, a, 1'b1, b, la, ua);
    chk("R9 local ring wins low out", 32'(la), 32'd1);
    chk("R9 descending waits", 32'(ua), 32'd0);
    chk("R9 low out carries local packet", 32'(lowOutPkt), 32'(a));
    one("R9 descending goes next", 0, b, 1, 0);
    cyc(1'b1, c, 1'b1, d, la, ua);
    chk("R9 upper ring wins up out", 32'(ua), 32'd1);
    chk("R9 climbing waits", 32'(la), 32'd0);
    chk("R9 up out carries upper packet", 32'(upOutPkt), 32'(d));
    one("R9 climbing goes next", 1, c, 0, 1);
  endtask

  task automatic t_backpressure();
    logic la, ua;
    logic [PktW-1:0] a = mk(3'd0, 2'd0, 7'd0, Mine, 5'd1);
    logic [PktW-1:0] b = mk(3'd0, 2'd0, 7'd0, Mine, 5'd2);
    lowOutReady = 1'b0;
    cyc(1'b1, a, 1'b0, '0, la, ua);
    chk("R10 first packet taken", 32'(la), 32'd1);
    cyc(1'b1, b, 1'b0, '0, la, ua);
    chk("R10 second packet refused", 32'(la), 32'd0);
    chk("R10 output held valid", 32'(lowOutValid), 32'd1);
    chk("R10 output held packet", 32'(lowOutPkt), 32'(a));
    lowOutReady = 1'b1;
    cyc(1'b1, b, 1'b0, '0, la, ua);
    chk("R10 second packet taken after drain", 32'(la), 32'd1);
    chk("R10 second packet out", 32'(lowOutPkt), 32'(b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_local_grants();
    t_exclusive_low();
    t_exclusive_up();
    t_foreign_inv();
    t_priority();
    t_backpressure();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule